// File: doc/BRIEF.md
# Program Counter Breakpoint Matcher

This block watches the program counter of a processor and raises a one-cycle trigger when the counter hits a configured instruction address. It holds four breakpoint address entries. Entry 0 is compared through a mask, so it can cover a whole aligned block of addresses. Entries 1 to 3 are exact compares, and each one takes part only when its own valid bit is set. The hits of all participating entries are ORed to form the breakpoint region.

A global enable turns PC triggering on. An invert control makes the trigger fire for program counters outside the region instead of inside it. Software sets up the entries, the mask and the control word through a simple register write port. The processor side presents each new program counter together with a valid strobe. The trigger output is registered and appears on the clock after the qualifying program counter.

Reset is asserted asynchronously and released synchronously inside the block. After reset, every enable, valid and invert bit is clear.

Top module: `pc_brk_matcher`

## Requirements
- R1: While reset is asserted and after it is released, `trig` is 0, and with no configuration writes no `trig` pulse occurs for any program counter (enable, invert and valid bits reset to 0, addresses and mask reset to 0).
- R2: A write with `wr_en`=1 updates one register at the next clock edge, selected by `wr_sel`: 0 to 3 are breakpoint entries 0 to 3, 4 is the entry-0 mask, 5 is the control word. The control word layout is bit 0 = enable, bit 1 = invert, bits 2, 3, 4 = valid bits of entries 1, 2, 3. Select codes 6 and 7 change nothing. A program counter presented in the same cycle as a write is judged against the old settings.
- R3: Entry 0 always takes part in the match. An address bit whose mask bit is 1 is left out of its compare, and every other bit must be equal.
- R4: The mask has no effect on entries 1 to 3, which compare every address bit.
- R5: Entries 1 to 3 contribute to the region only while their valid bit is 1.
- R6: With the enable bit at 0, `trig` stays 0 for every program counter.
- R7: With invert at 0, a qualifying program counter inside the region triggers. With invert at 1, a qualifying program counter outside the region triggers, and one inside it does not.
- R8: A program counter presented with `pc_vld`=0 never causes a trigger.
- R9: `trig` is 1 on exactly the clock after each qualifying program counter and lasts one cycle per qualifying program counter, so back-to-back hits give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| pc | input | 32 | Processor program counter |
| pc_vld | input | 1 | Program counter valid strobe |
| trig | output | 1 | Registered PC breakpoint trigger |

## Verification
The matcher is driven with program counters that equal an entry, differ from it only in masked bits, and differ in one unmasked bit. These cases separate a masked compare from an exact compare. The same addresses are aimed at entries 1 to 3 with their valid bits both cleared and set, and with a non-zero mask, to show that the mask is confined to entry 0 and that the valid bits gate the exact compares. The same hit and miss addresses are then repeated with enable off, with invert on, and with the valid strobe low, which tells the region logic apart from the qualification logic. A long stretch of random program counters from a small address pool, mixed with random register writes, checks the write-versus-compare timing and back-to-back pulses.

// File: rtl/pcbrk_pkg.sv
package pcbrk_pkg;
  // control word bit positions (software-visible)
  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_INV_BIT = 1;
  localparam int unsigned CTL_VLD_LSB = 2;

  typedef struct packed {
    logic en;
    logic inv;
  } trig_ctl_t;
endpackage

// File: rtl/pcbrk_rst_sync.sv
module pcbrk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pcbrk_regs.sv
module pcbrk_regs
  import pcbrk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_EXACT = 3,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [SEL_W-1:0]                   wr_sel,
  input  logic [ADDR_W-1:0]                  wr_data,
  output logic [NUM_EXACT:0][ADDR_W-1:0]     pbr,
  output logic [ADDR_W-1:0]                  mask,
  output logic [NUM_EXACT-1:0]               ent_vld,
  output trig_ctl_t                          ctl
);
  localparam int unsigned NUM_ENT = NUM_EXACT + 1;
  localparam int unsigned SEL_MSK = NUM_ENT;
  localparam int unsigned SEL_CTL = NUM_ENT + 1;
  localparam int unsigned CTL_W   = CTL_VLD_LSB + NUM_EXACT;

  logic [NUM_EXACT:0][ADDR_W-1:0] pbr_d, pbr_q;
  logic [ADDR_W-1:0] mask_d, mask_q;
  logic [CTL_W-1:0]  ctl_d, ctl_q;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[ADDR_W-1:CTL_W];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic ld;
    assign ld = wr_en && (wr_sel == SEL_W'(g));

    always_comb begin
      pbr_d[g] = pbr_q[g];
      if (ld) pbr_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pbr_q[g] <= '0;
      else        pbr_q[g] <= pbr_d[g];
    end
  end

  always_comb begin
    mask_d = mask_q;
    ctl_d  = ctl_q;
    if (wr_en && (wr_sel == SEL_W'(SEL_MSK))) mask_d = wr_data;
    if (wr_en && (wr_sel == SEL_W'(SEL_CTL))) ctl_d  = wr_data[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctl_q  <= '0;
    end else begin
      mask_q <= mask_d;
      ctl_q  <= ctl_d;
    end
  end

  assign pbr     = pbr_q;
  assign mask    = mask_q;
  assign ent_vld = ctl_q[CTL_W-1:CTL_VLD_LSB];
  assign ctl.en  = ctl_q[CTL_EN_BIT];
  assign ctl.inv = ctl_q[CTL_INV_BIT];

  // R2: a write to the control select lands on the enable bit next cycle
  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(SEL_CTL)) |=> (ctl.en == $past(wr_data[CTL_EN_BIT])));
  // R2: no write, no change of the mask
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));
endmodule

// File: rtl/pcbrk_cmp.sv
module pcbrk_cmp #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_EXACT = 3
) (
  input  logic [ADDR_W-1:0]              pc,
  input  logic [NUM_EXACT:0][ADDR_W-1:0] pbr,
  input  logic [ADDR_W-1:0]              mask,
  input  logic [NUM_EXACT-1:0]           ent_vld,
  output logic [NUM_EXACT:0]             ent_hit,
  output logic                           hit
);
  // entry 0: masked compare, always participates
  assign ent_hit[0] = ~|((pc ^ pbr[0]) & ~mask);

  // entries 1..NUM_EXACT: exact compare gated by own valid bit
  for (genvar g = 1; g <= NUM_EXACT; g++) begin : g_exact
    assign ent_hit[g] = ent_vld[g-1] && (pc == pbr[g]);
  end

  assign hit = |ent_hit;
endmodule

// File: rtl/pcbrk_trig.sv
module pcbrk_trig
  import pcbrk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pc_vld,
  input  logic      hit,
  input  trig_ctl_t ctl,
  output logic      trig
);
  logic qual;
  logic trig_d, trig_q;

  assign qual = pc_vld && ctl.en;

  always_comb begin
    trig_d = 1'b0;
    if (qual) trig_d = hit ^ ctl.inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig = trig_q;

  // R6, R8: nothing fires without an enabled, valid program counter
  assert_quiet_unqualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_vld && ctl.en) |=> !trig);
  // R7: inside the region with invert set never fires
  assert_inverted_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.inv && hit) |=> !trig);
  // R7: outside the region without invert never fires
  assert_plain_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.inv && !hit) |=> !trig);
endmodule

// File: rtl/pc_brk_matcher.sv
module pc_brk_matcher
  import pcbrk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_EXACT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_EXACT+3)-1:0] wr_sel,
  input  logic [ADDR_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             pc,
  input  logic                          pc_vld,
  output logic                          trig
);
  localparam int unsigned SEL_W = $clog2(NUM_EXACT + 3);

  logic                          rst_int_n;
  logic [NUM_EXACT:0][ADDR_W-1:0] pbr;
  logic [ADDR_W-1:0]             mask;
  logic [NUM_EXACT-1:0]          ent_vld;
  logic [NUM_EXACT:0]            ent_hit;
  logic                          hit;
  trig_ctl_t                     ctl;

  pcbrk_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pcbrk_regs #(.ADDR_W(ADDR_W), .NUM_EXACT(NUM_EXACT), .SEL_W(SEL_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .pbr     (pbr),
    .mask    (mask),
    .ent_vld (ent_vld),
    .ctl     (ctl)
  );

  pcbrk_cmp #(.ADDR_W(ADDR_W), .NUM_EXACT(NUM_EXACT)) i_cmp (
    .pc      (pc),
    .pbr     (pbr),
    .mask    (mask),
    .ent_vld (ent_vld),
    .ent_hit (ent_hit),
    .hit     (hit)
  );

  pcbrk_trig i_trig (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pc_vld (pc_vld),
    .hit    (hit),
    .ctl    (ctl),
    .trig   (trig)
  );

  // R9: every pulse traces back to a valid program counter one cycle earlier
  assert_pulse_source_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    trig |-> $past(pc_vld));
  // R4: an exact entry hit survives any mask value
  assert_exact_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pc_vld && ctl.en && !ctl.inv && ent_vld[0] && pc == pbr[1]) |=> trig);
  // R3: masked equality on entry 0 fires when enabled and not inverted
  assert_masked_hit_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pc_vld && ctl.en && !ctl.inv && ((pc & ~mask) == (pbr[0] & ~mask))) |=> trig);
  // R1: trigger is low while the internal reset is held
  always_comb begin
    if (!rst_int_n) assert_reset_low_R1: assert (!trig);
  end
endmodule

// File: tb/test_pc_brk_matcher.sv
module test_pc_brk_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pc = '0;
  logic        pc_vld = 1'b0;
  logic        trig;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  bit    checking = 1'b0;
  string phase    = "R1";

  // behavioural reference state
  logic [31:0] m_pbr [4];
  logic [31:0] m_mask;
  bit          m_en, m_inv;
  bit          m_vld [4];
  bit          exp_trig;

  always #10 clk = ~clk;  // 50 MHz

  pc_brk_matcher i_pc_brk_matcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pc(pc), .pc_vld(pc_vld), .trig(trig)
  );

  function automatic bit region(input logic [31:0] p);
    bit r;
    r = ((p & ~m_mask) == (m_pbr[0] & ~m_mask));
    for (int k = 1; k < 4; k++)
      if (m_vld[k] && p == m_pbr[k]) r = 1'b1;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin m_pbr[k] <= '0; m_vld[k] <= 1'b0; end
      m_mask <= '0; m_en <= 1'b0; m_inv <= 1'b0; exp_trig <= 1'b0;
    end else begin
      exp_trig <= pc_vld && m_en && (region(pc) ^ m_inv);
      if (wr_en) begin
        if (wr_sel < 3'd4) m_pbr[wr_sel] <= wr_data;
        else if (wr_sel == 3'd4) m_mask <= wr_data;
        else if (wr_sel == 3'd5) begin
          m_en  <= wr_data[0];
          m_inv <= wr_data[1];
          for (int k = 1; k < 4; k++) m_vld[k] <= wr_data[k+1];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      n_checks++;
      if (trig !== exp_trig) begin
        n_fails++;
        $display("FAIL %s: trig=%0b expected=%0b (pc=%h)", phase, trig, exp_trig, pc);
      end
    end
  end

  task automatic step(input bit v, input logic [31:0] p,
                      input bit we = 1'b0, input logic [2:0] s = '0,
                      input logic [31:0] d = '0);
    @(negedge clk);
    pc_vld = v; pc = p; wr_en = we; wr_sel = s; wr_data = d;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    step(1'b0, 32'h0, 1'b1, s, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    checking = 1'b1;
    phase = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 32'h0);
    step(1'b1, 32'h0); step(1'b1, 32'h0); step(1'b1, 32'h1234);

    // R2/R3: entry 0 and mask
    phase = "R2";
    wr(3'd0, 32'h0000_1000);
    wr(3'd5, 32'h1);
    step(1'b1, 32'h0000_1000);
    step(1'b1, 32'h0000_1004);
    phase = "R3";
    wr(3'd4, 32'h0000_000F);
    step(1'b1, 32'h0000_100A);
    step(1'b1, 32'h0000_1010);
    step(1'b1, 32'h0000_100F);

    // R2: same-cycle write does not affect that PC; R2 unused selects
    phase = "R2";
    step(1'b1, 32'h0000_3000, 1'b1, 3'd0, 32'h0000_3000);
    step(1'b1, 32'h0000_3000);
    step(1'b1, 32'h0000_3000, 1'b1, 3'd6, 32'hFFFF_FFFF);
    step(1'b1, 32'h0000_3000, 1'b1, 3'd7, 32'h0);
    step(1'b1, 32'h0000_3000);

    // R5/R4: exact entries and valid bits
    phase = "R5";
    wr(3'd1, 32'h0000_2000);
    step(1'b1, 32'h0000_2000);
    wr(3'd5, 32'h5);
    step(1'b1, 32'h0000_2000);
    phase = "R4";
    step(1'b1, 32'h0000_2003);
    wr(3'd4, 32'hFFFF_0000);
    step(1'b1, 32'h0001_2000);
    phase = "R5";
    wr(3'd2, 32'h0000_4000);
    wr(3'd3, 32'h0000_5000);
    step(1'b1, 32'h0000_4000);
    wr(3'd5, 32'h1D);
    step(1'b1, 32'h0000_4000);
    step(1'b1, 32'h0000_5000);

    // R6: disabled
    phase = "R6";
    wr(3'd5, 32'h1C);
    step(1'b1, 32'h0000_4000); step(1'b1, 32'h0000_2000); step(1'b1, 32'h0000_7777);
    wr(3'd5, 32'h1E);
    step(1'b1, 32'h0000_7777);

    // R7: invert
    phase = "R7";
    wr(3'd5, 32'h1F);
    step(1'b1, 32'h0000_7777);
    step(1'b1, 32'h0000_2000);
    step(1'b1, 32'h0000_5000);
    step(1'b1, 32'h0000_5001);

    // R8: strobe low
    phase = "R8";
    step(1'b0, 32'h0000_7777);
    wr(3'd5, 32'h1D);
    step(1'b0, 32'h0000_2000);
    step(1'b0, 32'h0000_4000);

    // R9: back-to-back and alternating pulses
    phase = "R9";
    step(1'b1, 32'h0000_2000); step(1'b1, 32'h0000_4000); step(1'b1, 32'h0000_5000);
    step(1'b1, 32'h0000_6000); step(1'b1, 32'h0000_2000); step(1'b0, 32'h0000_2000);
    step(1'b1, 32'h0000_4000);

    // mixed random traffic
    phase = "R9 random";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = {28'h0000_200, 4'h0} + ({$urandom} % 4) * 32'h1000 + ({$urandom} % 3);
      if (($urandom % 8) == 0)
        step($urandom % 2, a, 1'b1, 3'($urandom % 8),
             (($urandom % 2) != 0) ? a : 32'($urandom % 32));
      else
        step(($urandom % 4) != 0, a);
    end
    step(1'b0, 32'h0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule